// File: doc/BRIEF.md
# Drift-Tracking Serial Receiver

This block receives asynchronous serial frames made of one start bit, eight data bits and one stop bit. It runs from a local clock whose frequency may be off by a few percent. A bit-period register sets its timing. The register starts at a nominal count and follows the far end's real rate while bytes arrive. Each bit is sampled once, near its middle, and the same period applies to every bit whatever its value.

After each centre sample the receiver counts toward the spot where the next bit boundary should appear. It watches a narrow window of a few cycles around that spot. An edge inside the window is taken as a real boundary. If the edge is late the period grows by one fixed step, and if it is early the period shrinks by one step. Edges outside the window leave the period alone, as does a run of equal bits with no edge at all. So a single glitch can only move the timing a little.

The receiver samples the stop bit at its centre and then returns at once to waiting for the next start edge. Phase error therefore does not carry from one frame to the next, and frames may follow each other with no idle gap. A low stop bit is a framing error. It sets the period back to nominal.

Top module: `drift_uart_rx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, period_o equals the nominal 104, valid_o and frame_err_o are 0, and data_o is 0.
- R2: Data bits are assembled least significant bit first; a frame with a high stop bit yields data_o equal to the byte sent and a valid_o pulse exactly one cycle long.
- R3: A falling edge starts a frame only if the line is still low half a period later; a shorter low pulse produces neither valid_o nor frame_err_o, and the next proper frame is received correctly.
- R4: An edge that arrives inside the window later than expected raises period_o by one step (1 cycle), and one that arrives earlier lowers it by one step; the period never changes by more than one step at a time, except on a reload.
- R5: With no edge inside the window, including edges that fall outside it, period_o does not change; a frame sent 4 cycles per bit slow of nominal leaves period_o at 104.
- R6: period_o stays within the parameter limits PER_MIN and PER_MAX (94 and 114 by default) and saturates at them rather than stepping beyond them.
- R7: A low stop bit raises frame_err_o for exactly one cycle, issues no valid_o, and reloads period_o to 104 in that same cycle; valid_o and frame_err_o are never high together.
- R8: After the stop sample the receiver waits for a new start edge at once, so two frames sent back to back with no idle time are both received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Raw serial line, idle high |
| data_o | output | 8 | Last byte received |
| valid_o | output | 1 | One-cycle pulse when data_o takes a new byte |
| frame_err_o | output | 1 | One-cycle pulse when a stop bit is sampled low |
| period_o | output | PW (7) | Current bit-period estimate in clock cycles |

## Verification
The assertions assume the line idles high after reset and that reset lasts at least as many cycles as the synchronizer has stages, so the synchronizer holds the idle level when checking starts. They also assume the period changes only through the window rule and the reload, and that the far end's bit time stays within a few cycles of the current estimate, because a frame sent much farther off is not meant to be tracked. The stimulus holds every line level for whole clock cycles and changes it on the falling clock edge. It uses bit times from 102 to 108 cycles and returns the line high after each frame, except in the back-to-back and bad-stop-bit scenarios, where it sends those patterns on purpose.

// File: rtl/drift_rx_pkg.sv
package drift_rx_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned FRAME_IDX = BYTE_W;   // index of the stop sample

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              ferr;
    } rx_result_t;

    function automatic int unsigned trim_up(input int unsigned p,
                                            input int unsigned step,
                                            input int unsigned hi);
        return (p + step > hi) ? hi : p + step;
    endfunction

    function automatic int unsigned trim_down(input int unsigned p,
                                              input int unsigned step,
                                              input int unsigned lo);
        return (p < lo + step) ? lo : p - step;
    endfunction

endpackage

// File: rtl/drift_rx_sync.sv
module drift_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic rx_s_o,
    output logic edge_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rx_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rx_s_o = chain_q[STAGES-1];
    assign edge_o = rx_s_o ^ prev_q;
    assign fall_o = prev_q & ~rx_s_o;

endmodule

// File: rtl/drift_rx_period.sv
module drift_rx_period
    import drift_rx_pkg::*;
#(
    parameter int unsigned PER_NOM = 104,
    parameter int unsigned PER_MIN = 94,
    parameter int unsigned PER_MAX = 114,
    parameter int unsigned STEP    = 1,
    parameter int unsigned WIN     = 2,
    parameter int unsigned PW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          track_i,
    input  logic          edge_i,
    input  logic [PW-1:0] cnt_i,
    input  logic          reload_i,
    output logic [PW-1:0] period_o
);
    localparam logic [PW:0] WIN_V = (PW+1)'(WIN);

    logic [PW-1:0] period_q;
    logic [PW-1:0] target;
    logic          in_win;

    // boundary expected about half a period after the centre sample
    assign target = period_q - (period_q >> 1) - PW'(1);
    assign in_win = track_i && edge_i
                 && ({1'b0, cnt_i} + WIN_V >= {1'b0, target})
                 && ({1'b0, cnt_i} <= {1'b0, target} + WIN_V);

    always_ff @(posedge clk) begin
        if (rst || reload_i) begin
            period_q <= PW'(PER_NOM);
        end else if (in_win && (cnt_i > target)) begin
            period_q <= PW'(trim_up(int'(period_q), STEP, PER_MAX));
        end else if (in_win && (cnt_i < target)) begin
            period_q <= PW'(trim_down(int'(period_q), STEP, PER_MIN));
        end
    end

    assign period_o = period_q;

    p_period_range_r6: assert property (@(posedge clk) disable iff (rst)
        (period_q >= PW'(PER_MIN)) && (period_q <= PW'(PER_MAX)));

    p_step_size_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(reload_i) && (period_q > $past(period_q)))
            |-> (period_q - $past(period_q) <= PW'(STEP)));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(reload_i) && (period_q < $past(period_q)))
            |-> ($past(period_q) - period_q <= PW'(STEP)));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!edge_i && !reload_i) |=> $stable(period_q));

endmodule

// File: rtl/drift_rx_fsm.sv
module drift_rx_fsm
    import drift_rx_pkg::*;
#(
    parameter int unsigned PW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_s_i,
    input  logic              fall_i,
    input  logic [PW-1:0]     period_i,
    output logic [PW-1:0]     cnt_o,
    output logic              track_o,
    output logic              stop_bad_o,
    output rx_result_t        res_o
);
    localparam int unsigned IW = $clog2(FRAME_IDX + 1);

    rx_state_e         state_q;
    logic [PW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] shreg_q;
    rx_result_t        res_q;
    logic [PW-1:0]     half;
    logic              bit_tick;
    logic              stop_tick;

    assign half      = period_i >> 1;
    assign bit_tick  = (state_q == ST_BITS) && (cnt_q >= period_i - PW'(1));
    assign stop_tick = bit_tick && (idx_q == IW'(FRAME_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            res_q   <= '0;
        end else begin
            res_q.valid <= 1'b0;
            res_q.ferr  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (fall_i) state_q <= ST_START;
                end
                ST_START: begin
                    if (cnt_q == half - PW'(1)) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= rx_s_i ? ST_IDLE : ST_BITS;
                    end else begin
                        cnt_q <= cnt_q + PW'(1);
                    end
                end
                ST_BITS: begin
                    if (bit_tick) begin
                        cnt_q <= '0;
                        if (stop_tick) begin
                            state_q <= ST_IDLE;
                            if (rx_s_i) begin
                                res_q.valid <= 1'b1;
                                res_q.data  <= shreg_q;
                            end else begin
                                res_q.ferr  <= 1'b1;
                            end
                        end else begin
                            shreg_q <= {rx_s_i, shreg_q[BYTE_W-1:1]};
                            idx_q   <= idx_q + IW'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + PW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cnt_o      = cnt_q;
    assign track_o    = (state_q == ST_BITS);
    assign stop_bad_o = stop_tick && !rx_s_i;
    assign res_o      = res_q;

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        res_q.valid |=> !res_q.valid);

    p_ferr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        res_q.ferr |=> !res_q.ferr);

    p_excl_flags_r7: assert property (@(posedge clk) disable iff (rst)
        !(res_q.valid && res_q.ferr));

    p_result_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid || res_q.ferr) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/drift_uart_rx.sv
module drift_uart_rx
    import drift_rx_pkg::*;
#(
    parameter int unsigned PER_NOM     = 104,
    parameter int unsigned PER_MIN     = 94,
    parameter int unsigned PER_MAX     = 114,
    parameter int unsigned STEP        = 1,
    parameter int unsigned WIN         = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PW         = $clog2(PER_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              frame_err_o,
    output logic [PW-1:0]     period_o
);
    logic          rx_s;
    logic          rx_edge;
    logic          rx_fall;
    logic [PW-1:0] period;
    logic [PW-1:0] cnt;
    logic          track;
    logic          stop_bad;
    rx_result_t    res;

    drift_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .rx_i   (rx_i),
        .rx_s_o (rx_s),
        .edge_o (rx_edge),
        .fall_o (rx_fall)
    );

    drift_rx_period #(
        .PER_NOM (PER_NOM),
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX),
        .STEP    (STEP),
        .WIN     (WIN),
        .PW      (PW)
    ) period_i (
        .clk      (clk),
        .rst      (rst),
        .track_i  (track),
        .edge_i   (rx_edge),
        .cnt_i    (cnt),
        .reload_i (stop_bad),
        .period_o (period)
    );

    drift_rx_fsm #(
        .PW (PW)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .rx_s_i     (rx_s),
        .fall_i     (rx_fall),
        .period_i   (period),
        .cnt_o      (cnt),
        .track_o    (track),
        .stop_bad_o (stop_bad),
        .res_o      (res)
    );

    assign data_o      = res.data;
    assign valid_o     = res.valid;
    assign frame_err_o = res.ferr;
    assign period_o    = period;

    p_ferr_reload_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> (period_o == PW'(PER_NOM)));

endmodule

// File: tb/drift_uart_rx_tb.sv
module drift_uart_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic [7:0] data_o;
    logic       valid_o;
    logic       ferr_o;
    logic [6:0] period_o;
    logic [7:0] data_n;
    logic       valid_n;
    logic       ferr_n;
    logic [6:0] period_n;

    int total = 0;
    int fails = 0;
    int vcnt  = 0;
    int fcnt  = 0;
    logic [7:0] cap [0:63];

    always #2.5 clk = ~clk;

    drift_uart_rx dut_i (
        .clk (clk), .rst (rst), .rx_i (rx),
        .data_o (data_o), .valid_o (valid_o),
        .frame_err_o (ferr_o), .period_o (period_o)
    );

    // narrow limits so saturation is reachable with small rate offsets
    drift_uart_rx #(.PER_MIN(103), .PER_MAX(105)) dut_n (
        .clk (clk), .rst (rst), .rx_i (rx),
        .data_o (data_n), .valid_o (valid_n),
        .frame_err_o (ferr_n), .period_o (period_n)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                cap[vcnt[5:0]] = data_o;
                vcnt = vcnt + 1;
            end
            if (ferr_o) fcnt = fcnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rx  = 1'b1;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input int p, input logic stop_lvl);
        rx = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (p) @(negedge clk);
        end
        rx = stop_lvl;
        repeat (p) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic t_reset();
        rx  = 1'b1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(period_o == 7'd104, "R1 period in reset", period_o, 104);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid", valid_o, 0);
        check(ferr_o == 1'b0, "R1 frame_err", ferr_o, 0);
        check(data_o == 8'h00, "R1 data", data_o, 0);
        check(period_o == 7'd104, "R1 period after release", period_o, 104);
    endtask

    task automatic t_nominal();
        int v0;
        do_reset();
        v0 = vcnt;
        send_frame(8'hA5, 104, 1'b1);
        repeat (150) @(negedge clk);
        check(vcnt == v0 + 1, "R2 one valid pulse", vcnt - v0, 1);
        check(cap[v0[5:0]] == 8'hA5, "R2 data lsb first", cap[v0[5:0]], 8'hA5);
        check(period_o == 7'd104, "R5 nominal rate keeps period", period_o, 104);
    endtask

    task automatic t_outside_window();
        int v0;
        do_reset();
        v0 = vcnt;
        send_frame(8'h55, 108, 1'b1);
        repeat (150) @(negedge clk);
        check(cap[v0[5:0]] == 8'h55, "R5 data at offset rate", cap[v0[5:0]], 8'h55);
        check(period_o == 7'd104, "R5 edges outside window ignored", period_o, 104);
    endtask

    task automatic t_slow();
        int v0;
        do_reset();
        v0 = vcnt;
        send_frame(8'h55, 106, 1'b1);
        repeat (150) @(negedge clk);
        check(cap[v0[5:0]] == 8'h55, "R4 data slow rate", cap[v0[5:0]], 8'h55);
        check(period_o >= 7'd105 && period_o <= 7'd107, "R4 late edges raise period", period_o, 106);
        check(period_n == 7'd105, "R6 saturates at upper limit", period_n, 105);
    endtask

    task automatic t_fast();
        int v0;
        do_reset();
        v0 = vcnt;
        send_frame(8'h55, 102, 1'b1);
        repeat (150) @(negedge clk);
        check(cap[v0[5:0]] == 8'h55, "R4 data fast rate", cap[v0[5:0]], 8'h55);
        check(period_o < 7'd104 && period_o >= 7'd102, "R4 early edges lower period", period_o, 103);
        check(period_n == 7'd103, "R6 saturates at lower limit", period_n, 103);
    endtask

    task automatic t_false_start();
        int v0;
        int f0;
        do_reset();
        v0 = vcnt;
        f0 = fcnt;
        rx = 1'b0;
        repeat (20) @(negedge clk);
        rx = 1'b1;
        repeat (200) @(negedge clk);
        check(vcnt == v0, "R3 glitch gives no valid", vcnt - v0, 0);
        check(fcnt == f0, "R3 glitch gives no frame error", fcnt - f0, 0);
        send_frame(8'h3E, 104, 1'b1);
        repeat (150) @(negedge clk);
        check(vcnt == v0 + 1 && cap[v0[5:0]] == 8'h3E, "R3 frame after glitch", cap[v0[5:0]], 8'h3E);
    endtask

    task automatic t_bad_stop();
        int v0;
        int f0;
        do_reset();
        v0 = vcnt;
        f0 = fcnt;
        send_frame(8'h55, 106, 1'b0);
        repeat (150) @(negedge clk);
        check(fcnt == f0 + 1, "R7 one frame error pulse", fcnt - f0, 1);
        check(vcnt == v0, "R7 no valid on bad stop", vcnt - v0, 0);
        check(period_o == 7'd104, "R7 period reloaded", period_o, 104);
    endtask

    task automatic t_back_to_back();
        int v0;
        do_reset();
        v0 = vcnt;
        send_frame(8'h3C, 104, 1'b1);
        send_frame(8'hC3, 104, 1'b1);
        repeat (150) @(negedge clk);
        check(vcnt == v0 + 2, "R8 two frames received", vcnt - v0, 2);
        check(cap[v0[5:0]] == 8'h3C, "R8 first byte", cap[v0[5:0]], 8'h3C);
        check(cap[(v0 + 1) % 64] == 8'hC3, "R8 second byte", cap[(v0 + 1) % 64], 8'hC3);
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_outside_window();
        t_slow();
        t_fast();
        t_false_start();
        t_bad_stop();
        t_back_to_back();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        fails = fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule